// File: doc/BRIEF.md
# Streaming GF(2) Index Permuter

This block reorders fixed-size datasets that arrive as a stream. A dataset holds 2^N words and enters over 2^K parallel lanes, so it takes 2^(N-K) consecutive cycles to arrive. Each output position is a linear function over GF(2) of the input position bits. An invertible N x N bit-matrix, fixed when the block is built, defines that function. Bit reversal is the usual case.

Several matrices can be configured. They are used in rotation: the first accepted dataset uses matrix 0, the next uses matrix 1, and so on, wrapping back to 0. Words are written into a pair of alternating register banks at addresses computed from the matrix, then read back in sequential order.

A build-time mode picks how the read and write sides are sequenced. The mode sets the spacing rule for new datasets and the latency. A start pulse that breaks the rule is dropped and raises a one-cycle error flag.

Top module: `gf2_stream_permuter`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` and `start_err` are low and stay low until a dataset has been accepted.
- R2: The word on lane p in slot s of a dataset has input index i = s*2^K + p. It appears on lane j mod 2^K in output slot j / 2^K, where bit r of j is the XOR over c of M[r][c] AND bit c of i. Element M[r][c] of matrix m is bit m*N*N + r*N + c of `PERM_BITS`.
- R3: Accepted datasets use the matrices in turn: 0, 1, ..., NMAT-1, then 0 again. A rejected start does not advance the rotation.
- R4: The first output cycle comes LATENCY cycles after the start cycle. LATENCY is 2^(N-K)+1 for MODE 0 and 1, and 2^(N-K)+2 for MODE 2. `out_valid` is then high for exactly 2^(N-K) consecutive cycles per dataset.
- R5: In every mode, a start exactly 2^(N-K) cycles after the previous accepted start is accepted, so datasets can follow each other with no gap.
- R6: In MODE 0 (independent read and write sequencing), a start is accepted whenever no dataset is still being input.
- R7: In MODE 1 (read and write share one slot sequence) and MODE 2 (one shared address port), a start is accepted in only two cases. Either it follows the previous accepted start back to back, or it comes at least 2*2^(N-K) cycles after it, once that dataset has fully left. Any other start is rejected.
- R8: In every mode, a start that arrives while a dataset is still being input is rejected. For any rejected start, `start_err` is high in the following cycle only. The rejected start's data is ignored and the datasets already in flight come out unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_start | input | 1 | Marks the first cycle of a dataset |
| in_data | input | 2^K*W | Input lanes, lane p at bits p*W +: W |
| out_valid | output | 1 | Output lanes carry permuted data |
| out_data | output | 2^K*W | Output lanes, lane p at bits p*W +: W |
| start_err | output | 1 | One-cycle flag for a rejected start |

## Verification
The hardest situation to reach is a start that lands while the previous dataset is being read out. In the shared-sequence modes such a start is legal only in the exact cycle the read begins, and rejected a cycle later. Three instances, one per mode, receive the same stimulus. It begins with directed starts at chosen offsets: idle, back to back, mid-write, and mid-read. It then continues with seeded random gaps drawn from three groups: exactly one dataset length, between one and two lengths, and short. The same start pulse is therefore accepted by one mode and rejected by another, and the rotation of matrices drifts apart between instances.

// File: rtl/gf2_perm_pkg.sv
// Shared types and constants for the streaming GF(2) permuter.
// Assumes N <= 8 and NMAT <= 4, so every matrix set fits in PERM_W bits.
package gf2_perm_pkg;

    localparam int PERM_W = 256;

    typedef enum int {
        SEQ_SPLIT  = 0,
        SEQ_SHARED = 1,
        SEQ_ONEPORT = 2
    } seq_mode_e;

    // Builds the default matrix set: even entries reverse the bits, odd entries are lower bidiagonal.
    function automatic logic [PERM_W-1:0] default_perm(int n, int nm);
        logic [PERM_W-1:0] v;
        v = '0;
        for (int m = 0; m < nm; m++)
            for (int r = 0; r < n; r++)
                for (int c = 0; c < n; c++)
                    if ((m % 2 == 0) ? (r == n - 1 - c) : (r == c || r == c + 1))
                        v[(m * n + r) * n + c] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/gf2_perm_seq.sv
// Sequencer: decides whether a start is accepted, tracks the write and read slots,
// alternates the bank pair and rotates the matrix index.
// Assumes N > K, so one dataset spans at least two cycles.
module gf2_perm_seq #(
    parameter int N = 4,
    parameter int K = 1,
    parameter int NMAT = 2,
    parameter gf2_perm_pkg::seq_mode_e MODE = gf2_perm_pkg::SEQ_SPLIT,
    localparam int SW = N - K,
    localparam int MW = (NMAT > 1) ? $clog2(NMAT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_start,
    output logic          wr_go,
    output logic [SW-1:0] wr_slot,
    output logic          wr_bank,
    output logic [MW-1:0] wr_mat,
    output logic          rd_go,
    output logic [SW-1:0] rd_slot,
    output logic          rd_bank,
    output logic          start_err
);
    localparam int T = 1 << SW;
    localparam logic [SW-1:0] LAST = SW'(T - 1);

    logic          wr_act_q, rd_act_q, wr_bank_q, rd_bank_q, err_q;
    logic [SW-1:0] wr_cnt_q, rd_cnt_q;
    logic [MW-1:0] mat_q, mat_next;
    logic          accept, wr_last;

    // Spacing rule of the configured mode.
    always_comb begin
        if (MODE == gf2_perm_pkg::SEQ_SPLIT)
            accept = in_start && !wr_act_q;
        else
            accept = in_start && !wr_act_q && (!rd_act_q || rd_cnt_q == '0);
    end

    // Current write slot, bank and matrix, including a dataset starting this cycle.
    always_comb begin
        mat_next = (mat_q == MW'(NMAT - 1)) ? '0 : mat_q + 1'b1;
        wr_go    = accept || wr_act_q;
        wr_slot  = accept ? '0 : wr_cnt_q;
        wr_bank  = accept ? ~wr_bank_q : wr_bank_q;
        wr_mat   = accept ? mat_next : mat_q;
        wr_last  = wr_go && (wr_slot == LAST);
    end

    // Write-side state: active flag, slot counter, bank and matrix rotation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_act_q  <= 1'b0;
            wr_cnt_q  <= '0;
            wr_bank_q <= 1'b1;
            mat_q     <= MW'(NMAT - 1);
        end else if (accept) begin
            wr_act_q  <= 1'b1;
            wr_cnt_q  <= SW'(1);
            wr_bank_q <= ~wr_bank_q;
            mat_q     <= mat_next;
        end else if (wr_act_q) begin
            wr_cnt_q <= wr_cnt_q + 1'b1;
            if (wr_last) wr_act_q <= 1'b0;
        end
    end

    // Read-side state: launched when a bank has been filled completely.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_act_q  <= 1'b0;
            rd_cnt_q  <= '0;
            rd_bank_q <= 1'b0;
        end else if (wr_last) begin
            rd_act_q  <= 1'b1;
            rd_cnt_q  <= '0;
            rd_bank_q <= wr_bank;
        end else if (rd_act_q) begin
            rd_cnt_q <= rd_cnt_q + 1'b1;
            if (rd_cnt_q == LAST) rd_act_q <= 1'b0;
        end
    end

    // Error flag for a start that breaks the spacing rule.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= in_start && !accept;
    end

    assign rd_go     = rd_act_q;
    assign rd_slot   = rd_cnt_q;
    assign rd_bank   = rd_bank_q;
    assign start_err = err_q;

    AST_READ_FULL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_act_q) |-> $past(rd_cnt_q) == LAST); // R4

    AST_ERR_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> $past(in_start)); // R8

endmodule

// File: rtl/gf2_perm_addr.sv
// Address generator: maps each lane's input index to its output index with the
// selected GF(2) matrix. Purely combinational, one instance of the map per lane.
module gf2_perm_addr #(
    parameter int N = 4,
    parameter int K = 1,
    parameter int NMAT = 2,
    parameter logic [gf2_perm_pkg::PERM_W-1:0] PERM_BITS = '0,
    localparam int P = 1 << K,
    localparam int SW = N - K,
    localparam int MW = (NMAT > 1) ? $clog2(NMAT) : 1
) (
    input  logic [SW-1:0]       slot,
    input  logic [MW-1:0]       mat,
    output logic [P-1:0][N-1:0] addr
);
    // Multiplies an index by matrix m over GF(2).
    function automatic logic [N-1:0] gf2_map(int m, logic [N-1:0] idx);
        logic [N-1:0] res;
        for (int r = 0; r < N; r++) begin
            res[r] = 1'b0;
            for (int c = 0; c < N; c++)
                res[r] = res[r] ^ (PERM_BITS[(m * N + r) * N + c] & idx[c]);
        end
        return res;
    endfunction

    for (genvar p = 0; p < P; p++) begin : g_lane
        localparam logic [K-1:0] LANE = K'(p);
        // Destination address of this lane's word.
        always_comb addr[p] = gf2_map(int'(mat), {slot, LANE});
    end

endmodule

// File: rtl/gf2_perm_store.sv
// Two alternating register banks: scattered writes at matrix-derived addresses,
// sequential reads by slot. MODE 2 adds one read stage because a single address
// port serves both the read and the write side.
module gf2_perm_store #(
    parameter int N = 4,
    parameter int K = 1,
    parameter int W = 8,
    parameter gf2_perm_pkg::seq_mode_e MODE = gf2_perm_pkg::SEQ_SPLIT,
    localparam int P = 1 << K,
    localparam int D = 1 << N,
    localparam int SW = N - K
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_go,
    input  logic                 wr_bank,
    input  logic [P-1:0][N-1:0]  wr_addr,
    input  logic [P-1:0][W-1:0]  wr_data,
    input  logic                 rd_go,
    input  logic                 rd_bank,
    input  logic [SW-1:0]        rd_slot,
    output logic                 out_valid,
    output logic [P-1:0][W-1:0]  out_data
);
    logic [W-1:0]         mem [2][D];
    logic [P-1:0][W-1:0]  rd_word, da_q;
    logic                 va_q;

    // Scatter the incoming lanes into the selected bank.
    always_ff @(posedge clk) begin
        if (wr_go)
            for (int p = 0; p < P; p++)
                mem[wr_bank][wr_addr[p]] <= wr_data[p];
    end

    for (genvar p = 0; p < P; p++) begin : g_rd
        localparam logic [K-1:0] LANE = K'(p);
        // Gather word of this lane for the current read slot.
        always_comb rd_word[p] = mem[rd_bank][{rd_slot, LANE}];
    end

    // First read stage: valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) va_q <= 1'b0;
        else        va_q <= rd_go;
    end

    // First read stage: data lanes.
    always_ff @(posedge clk) da_q <= rd_word;

    if (MODE == gf2_perm_pkg::SEQ_ONEPORT) begin : g_extra
        logic                vb_q;
        logic [P-1:0][W-1:0] db_q;
        // Second read stage: valid flag.
        always_ff @(posedge clk) begin
            if (!rst_n) vb_q <= 1'b0;
            else        vb_q <= va_q;
        end
        // Second read stage: data lanes.
        always_ff @(posedge clk) db_q <= da_q;
        assign out_valid = vb_q;
        assign out_data  = db_q;
    end else begin : g_direct
        assign out_valid = va_q;
        assign out_data  = da_q;
    end

endmodule

// File: rtl/gf2_stream_permuter.sv
// Top level of the streaming GF(2) index permuter. Joins the sequencer, the
// per-lane address map and the bank pair. Assumes 1 <= K < N, N <= 8, NMAT <= 4.
module gf2_stream_permuter #(
    parameter int N = 4,
    parameter int K = 1,
    parameter int W = 8,
    parameter int NMAT = 2,
    parameter gf2_perm_pkg::seq_mode_e MODE = gf2_perm_pkg::SEQ_SPLIT,
    parameter logic [gf2_perm_pkg::PERM_W-1:0] PERM_BITS = gf2_perm_pkg::default_perm(N, NMAT),
    localparam int P = 1 << K,
    localparam int SW = N - K,
    localparam int MW = (NMAT > 1) ? $clog2(NMAT) : 1,
    localparam int LATENCY = (1 << SW) + 1 + ((MODE == gf2_perm_pkg::SEQ_ONEPORT) ? 1 : 0)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_start,
    input  logic [P*W-1:0] in_data,
    output logic           out_valid,
    output logic [P*W-1:0] out_data,
    output logic           start_err
);
    logic                wr_go, wr_bank, rd_go, rd_bank;
    logic [SW-1:0]       wr_slot, rd_slot;
    logic [MW-1:0]       wr_mat;
    logic [P-1:0][N-1:0] wr_addr;
    logic [P-1:0][W-1:0] lanes_in, lanes_out;

    initial assert (K >= 1 && N > K && N <= 8 && NMAT >= 1 && NMAT * N * N <= gf2_perm_pkg::PERM_W);

    assign lanes_in = in_data;
    assign out_data = lanes_out;

    gf2_perm_seq #(.N(N), .K(K), .NMAT(NMAT), .MODE(MODE)) u_seq (
        .clk(clk), .rst_n(rst_n), .in_start(in_start),
        .wr_go(wr_go), .wr_slot(wr_slot), .wr_bank(wr_bank), .wr_mat(wr_mat),
        .rd_go(rd_go), .rd_slot(rd_slot), .rd_bank(rd_bank), .start_err(start_err)
    );

    gf2_perm_addr #(.N(N), .K(K), .NMAT(NMAT), .PERM_BITS(PERM_BITS)) u_addr (
        .slot(wr_slot), .mat(wr_mat), .addr(wr_addr)
    );

    gf2_perm_store #(.N(N), .K(K), .W(W), .MODE(MODE)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_go(wr_go), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(lanes_in),
        .rd_go(rd_go), .rd_bank(rd_bank), .rd_slot(rd_slot),
        .out_valid(out_valid), .out_data(lanes_out)
    );

    AST_BUF_SEPARATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && rd_go) |-> (wr_bank != rd_bank)); // R5

    if (MODE == gf2_perm_pkg::SEQ_ONEPORT) begin : g_chk_two
        AST_RD_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            rd_go |=> ##1 out_valid); // R4
    end else begin : g_chk_one
        AST_RD_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            rd_go |=> out_valid); // R4
    end

endmodule

// File: tb/sim_gf2_stream_permuter.sv
// Bench: three instances (one per mode) share one stimulus; a bench-side model
// predicts acceptance, matrix rotation, output timing and word placement.
module sim_gf2_stream_permuter;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4, K = 1, W = 8, NMAT = 2;
    localparam int P = 1 << K, T = 1 << (N - K), DW = P * W;
    localparam int NC = 3000, NE = NC + 48;

    // Bench's own matrices: even m reverses bits, odd m is lower bidiagonal.
    function automatic bit mbit(int m, int r, int c);
        return (m % 2 == 0) ? (r == N - 1 - c) : (r == c || r == c + 1);
    endfunction

    function automatic logic [gf2_perm_pkg::PERM_W-1:0] build_bits();
        logic [gf2_perm_pkg::PERM_W-1:0] v = '0;
        for (int m = 0; m < NMAT; m++)
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++)
                    v[(m * N + r) * N + c] = mbit(m, r, c);
        return v;
    endfunction

    function automatic int map_idx(int m, int i);
        int j = 0;
        for (int r = 0; r < N; r++) begin
            bit b = 1'b0;
            for (int c = 0; c < N; c++) b = b ^ (mbit(m, r, c) & i[c]);
            j = j | (int'(b) << r);
        end
        return j;
    endfunction

    localparam logic [gf2_perm_pkg::PERM_W-1:0] BITS = build_bits();

    logic clk = 1'b0, rst_n = 1'b0, in_start = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic ov [3];
    logic er [3];
    logic [DW-1:0] od [3];

    always #(CLK_PERIOD / 2) clk = ~clk;

    gf2_stream_permuter #(.N(N), .K(K), .W(W), .NMAT(NMAT), .MODE(gf2_perm_pkg::SEQ_SPLIT), .PERM_BITS(BITS)) u0 (
        .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_data(in_data),
        .out_valid(ov[0]), .out_data(od[0]), .start_err(er[0]));
    gf2_stream_permuter #(.N(N), .K(K), .W(W), .NMAT(NMAT), .MODE(gf2_perm_pkg::SEQ_SHARED), .PERM_BITS(BITS)) u1 (
        .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_data(in_data),
        .out_valid(ov[1]), .out_data(od[1]), .start_err(er[1]));
    gf2_stream_permuter #(.N(N), .K(K), .W(W), .NMAT(NMAT), .MODE(gf2_perm_pkg::SEQ_ONEPORT), .PERM_BITS(BITS)) u2 (
        .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_data(in_data),
        .out_valid(ov[2]), .out_data(od[2]), .start_err(er[2]));

    int checks = 0, fails = 0;
    bit exp_v [3][NE];
    bit exp_e [3][NE];
    logic [W-1:0] exp_d [3][NE][P];
    int last_st [3], act_st [3], act_m [3], mat_c [3];
    int lat [3] = '{T + 1, T + 1, T + 2};
    bit done = 1'b0;

    task automatic check(bit ok, string req, string what, int d, int cyc, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s u%0d cyc %0d %s: actual %0h expected %0h", req, d, cyc, what, act, exp);
        end
    endtask

    // Model one cycle of stimulus for every instance.
    task automatic model(int cyc, bit st, logic [DW-1:0] data);
        for (int d = 0; d < 3; d++) begin
            if (st) begin
                bit ok;
                if (d == 0) ok = (cyc >= last_st[d] + T);                          // R6 R8
                else        ok = (cyc == last_st[d] + T) || (cyc >= last_st[d] + 2 * T); // R5 R7
                if (ok) begin
                    last_st[d] = cyc; act_st[d] = cyc; act_m[d] = mat_c[d];
                    mat_c[d] = (mat_c[d] + 1) % NMAT;                               // R3
                end else exp_e[d][cyc + 1] = 1'b1;
            end
            if (act_st[d] >= 0 && cyc - act_st[d] < T) begin
                int s = cyc - act_st[d];
                for (int p = 0; p < P; p++) begin
                    int j = map_idx(act_m[d], s * P + p);
                    int oc = act_st[d] + lat[d] + j / P;
                    exp_v[d][oc] = 1'b1;
                    exp_d[d][oc][j % P] = data[p * W +: W];
                end
            end
        end
    endtask

    initial begin
        int next_st;
        int dir [6] = '{0, 40, 48, 56, 59, 66};
        int di = 0;
        void'($urandom(32'd1234));
        for (int d = 0; d < 3; d++) begin
            last_st[d] = -1000; act_st[d] = -1; mat_c[d] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int d = 0; d < 3; d++) begin
            check(ov[d] == 1'b0, "R1", "out_valid in reset", d, -1, ov[d], 0);
            check(er[d] == 1'b0, "R1", "start_err in reset", d, -1, er[d], 0);
        end
        rst_n = 1'b1;
        next_st = dir[0];
        for (int cyc = 0; cyc < NC; cyc++) begin
            bit st;
            for (int d = 0; d < 3; d++) begin
                check(ov[d] == exp_v[d][cyc], "R4", "out_valid", d, cyc, ov[d], exp_v[d][cyc]);
                check(er[d] == exp_e[d][cyc], "R5 R6 R7 R8", "start_err", d, cyc, er[d], exp_e[d][cyc]);
                if (exp_v[d][cyc] && ov[d])
                    for (int p = 0; p < P; p++)
                        check(od[d][p * W +: W] == exp_d[d][cyc][p], "R2 R3", "lane word", d, cyc,
                              od[d][p * W +: W], exp_d[d][cyc][p]);
            end
            st = (cyc == next_st) && (cyc < NC - 48);
            if (cyc == next_st) begin
                if (di < 5) begin
                    di++; next_st = dir[di];
                end else begin
                    int r = int'($urandom % 4);
                    if (next_st < 100)  next_st = 100;
                    else if (r < 2)     next_st = cyc + T;
                    else if (r == 2)    next_st = cyc + T + 1 + int'($urandom % T);
                    else                next_st = cyc + 1 + int'($urandom % (3 * T));
                end
            end
            in_start = st;
            in_data = DW'($urandom);
            model(cyc, st, in_data);
            @(negedge clk);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL R4 watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule